// File: doc/BRIEF.md
# Coprocessor Access Error Checker

This block watches every bus access that a secondary coprocessor issues and decides, in a single cycle, whether the access is legal. It looks at the address, the access kind (load-store, opcode fetch or vector fetch), the direction, the size, the operating mode and the flash security state. It also takes a verdict from a companion RAM-protection checker. An illegal access produces a one-cycle error strobe toward the coprocessor. A cause register keeps the reason for the most recent error.

The system address map is modelled as four parameterised windows: a peripheral register window, a RAM window, a flash window, and everything else, which counts as unimplemented. Legal load-store writes produce a downstream write-enable pulse. Reads return the memory's data when legal and zero when flagged.

Each access is presented for one cycle on a plain valid strobe and is always taken. There is no back-pressure: the checker never stalls and evaluates one access per clock. All outputs change on the clock edge after the accepted access. Read data from the memory is expected in that same following cycle.

Top module: `coproc_acc_checker`

## Requirements
- R1: A word access (`acc_word`=1) at an odd address is an error for every access kind, with cause code 1.
- R2: An opcode fetch (`acc_kind`=1) or vector fetch (`acc_kind`=2) into the register window is an error with cause code 2. A load-store access (`acc_kind`=0) to that window is legal.
- R3: A load-store write into the flash window is an error with cause code 3, in both operating modes.
- R4: With `flash_locked`=1 and `mode_expanded`=1, any access kind into the flash window is an error with cause code 4.
- R5: Any access kind to an address outside the register, RAM and flash windows is an error with cause code 5.
- R6: A load-store write with `ramprot_deny`=1 is an error with cause code 6 and is not written. `ramprot_deny` has no effect on reads or fetches.
- R7: `err_pulse` is high for exactly the one cycle after an accepted (`acc_valid`=1) illegal access and is low after idle cycles. Several simultaneous causes still give a single pulse.
- R8: `err_cause` takes the lowest-numbered active cause (1 is the highest priority) with each error. It holds between errors and is 0 after reset.
- R9: `mem_we` pulses one cycle after a legal load-store write only. It is never high together with `err_pulse`. The direction input is ignored for fetches, which are always reads.
- R10: `rd_valid` pulses one cycle after every accepted read or fetch. In that cycle `rd_data` equals `mem_rdata` for a legal access and is zero for a flagged one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_kind | input | 2 | 0 load-store, 1 opcode fetch, 2 vector fetch (3 treated as a fetch) |
| acc_write | input | 1 | 1 = write (load-store only) |
| acc_word | input | 1 | 1 = word, 0 = byte |
| mode_expanded | input | 1 | Device in an expanded operating mode |
| flash_locked | input | 1 | Flash security active |
| ramprot_deny | input | 1 | Companion RAM-protection verdict rejecting this write |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after the access |
| err_pulse | output | 1 | One-cycle access-error strobe |
| err_cause | output | 3 | Cause code of the most recent error |
| mem_we | output | 1 | Downstream write enable |
| rd_valid | output | 1 | Read result available |
| rd_data | output | DATA_W | Read data, zeroed on error |

## Verification
The bench runs a reduced map of 1024 addresses. It sweeps every address against every combination of kind, direction, size, operating mode and security state, and it varies the protection verdict with address bits. Both parities at each window edge separate R1 from the window rules. Fetch against load-store into the register window isolates R2. Writes against reads in flash, under all four mode and security pairs, separate R3 from R4. Cases where several rules fire at once confirm that only the highest-priority code is reported. Idle gaps between blocks confirm that no pulse appears and the cause code holds.

// File: rtl/coproc_acc_pkg.sv
package coproc_acc_pkg;
  typedef enum logic [1:0] {
    KIND_LS  = 2'd0,
    KIND_OPF = 2'd1,
    KIND_VEC = 2'd2,
    KIND_RSV = 2'd3
  } acc_kind_e;

  localparam int unsigned NCAUSE  = 6;
  localparam int unsigned CAUSE_W = 3;

  // bit index i of the hit vector reports cause code i+1
  localparam int unsigned HIT_MISALIGN  = 0;
  localparam int unsigned HIT_REGFETCH  = 1;
  localparam int unsigned HIT_FLASHWR   = 2;
  localparam int unsigned HIT_LOCKED    = 3;
  localparam int unsigned HIT_UNIMPL    = 4;
  localparam int unsigned HIT_RAMPROT   = 5;
endpackage

// File: rtl/coproc_addr_decode.sv
module coproc_addr_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned REG_LO   = 'h0000,
  parameter int unsigned REG_HI   = 'h07FF,
  parameter int unsigned RAM_LO   = 'h1000,
  parameter int unsigned RAM_HI   = 'h3FFF,
  parameter int unsigned FLASH_LO = 'h8000,
  parameter int unsigned FLASH_HI = 'hFFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_reg,
  output logic              in_ram,
  output logic              in_flash,
  output logic              in_impl
);
  localparam int unsigned CMP_W = 32;
  logic [CMP_W-1:0] a;

  always_comb begin
    a        = CMP_W'(addr);
    in_reg   = (a >= REG_LO)   && (a <= REG_HI);
    in_ram   = (a >= RAM_LO)   && (a <= RAM_HI);
    in_flash = (a >= FLASH_LO) && (a <= FLASH_HI);
    in_impl  = in_reg || in_ram || in_flash;
  end
endmodule

// File: rtl/coproc_rule_eval.sv
module coproc_rule_eval
  import coproc_acc_pkg::*;
(
  input  logic              odd_addr,
  input  logic [1:0]        kind,
  input  logic              write,
  input  logic              word,
  input  logic              expanded,
  input  logic              locked,
  input  logic              rp_deny,
  input  logic              in_reg,
  input  logic              in_flash,
  input  logic              in_impl,
  output logic [NCAUSE-1:0] hits,
  output logic              ls_write
);
  logic is_fetch;

  always_comb begin
    is_fetch = (kind != KIND_LS);
    ls_write = !is_fetch && write;
    hits               = '0;
    hits[HIT_MISALIGN] = word && odd_addr;
    hits[HIT_REGFETCH] = is_fetch && in_reg;
    hits[HIT_FLASHWR]  = ls_write && in_flash;
    hits[HIT_LOCKED]   = locked && expanded && in_flash;
    hits[HIT_UNIMPL]   = !in_impl;
    hits[HIT_RAMPROT]  = ls_write && rp_deny;
  end
endmodule

// File: rtl/coproc_prio_enc.sv
module coproc_prio_enc #(
  parameter int unsigned N = 6,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] hits,
  output logic         any,
  output logic [W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) code = W'(i + 1);
    end
    any = |hits;
  end
endmodule

// File: rtl/coproc_acc_checker.sv
module coproc_acc_checker
  import coproc_acc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned REG_LO   = 'h0000,
  parameter int unsigned REG_HI   = 'h07FF,
  parameter int unsigned RAM_LO   = 'h1000,
  parameter int unsigned RAM_HI   = 'h3FFF,
  parameter int unsigned FLASH_LO = 'h8000,
  parameter int unsigned FLASH_HI = 'hFFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [1:0]          acc_kind,
  input  logic                acc_write,
  input  logic                acc_word,
  input  logic                mode_expanded,
  input  logic                flash_locked,
  input  logic                ramprot_deny,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                err_pulse,
  output logic [CAUSE_W-1:0]  err_cause,
  output logic                mem_we,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);
  logic              in_reg, in_ram, in_flash, in_impl;
  logic [NCAUSE-1:0] hits;
  logic              ls_write, any_hit;
  logic [CAUSE_W-1:0] code;

  coproc_addr_decode #(
    .ADDR_W(ADDR_W), .REG_LO(REG_LO), .REG_HI(REG_HI),
    .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
    .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI)
  ) u_dec (
    .addr(acc_addr), .in_reg(in_reg), .in_ram(in_ram),
    .in_flash(in_flash), .in_impl(in_impl)
  );

  coproc_rule_eval u_rules (
    .odd_addr(acc_addr[0]), .kind(acc_kind), .write(acc_write),
    .word(acc_word), .expanded(mode_expanded), .locked(flash_locked),
    .rp_deny(ramprot_deny), .in_reg(in_reg), .in_flash(in_flash),
    .in_impl(in_impl), .hits(hits), .ls_write(ls_write)
  );

  coproc_prio_enc #(.N(NCAUSE), .W(CAUSE_W)) u_prio (
    .hits(hits), .any(any_hit), .code(code)
  );

  logic err_q, we_q, rdv_q, rd_ok_q;
  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      we_q    <= 1'b0;
      rdv_q   <= 1'b0;
      rd_ok_q <= 1'b0;
      cause_q <= '0;
    end else begin
      err_q   <= acc_valid && any_hit;
      we_q    <= acc_valid && ls_write && !any_hit;
      rdv_q   <= acc_valid && !ls_write;
      rd_ok_q <= acc_valid && !ls_write && !any_hit;
      if (acc_valid && any_hit) cause_q <= code;
    end
  end

  assign err_pulse = err_q;
  assign err_cause = cause_q;
  assign mem_we    = we_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rd_ok_q ? mem_rdata : '0;

  p_misalign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_word && acc_addr[0]) |=> (err_pulse && err_cause == 3'd1));
  p_flash_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == KIND_LS && acc_write && in_flash) |=> err_pulse);
  p_need_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !err_pulse);
  p_cause_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_cause != '0));
  p_cause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_pulse |=> (err_pulse || $stable(err_cause)));
  p_we_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !err_pulse);
  p_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && err_pulse) |-> (rd_data == '0));
  p_rd_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, mem_we}));
endmodule

// File: tb/coproc_acc_checker_tb.sv
module coproc_acc_checker_tb;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 16;
  localparam int unsigned R_LO = 'h000, R_HI = 'h07F;
  localparam int unsigned M_LO = 'h100, M_HI = 'h1FF;
  localparam int unsigned F_LO = 'h200, F_HI = 'h3FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, acc_word = 0;
  logic mode_expanded = 0, flash_locked = 0, ramprot_deny = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_kind = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic err_pulse, mem_we, rd_valid;
  logic [2:0] err_cause;
  logic [DW-1:0] rd_data;

  always #4 clk = ~clk;

  coproc_acc_checker #(
    .ADDR_W(AW), .DATA_W(DW), .REG_LO(R_LO), .REG_HI(R_HI),
    .RAM_LO(M_LO), .RAM_HI(M_HI), .FLASH_LO(F_LO), .FLASH_HI(F_HI)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_write(acc_write), .acc_word(acc_word),
    .mode_expanded(mode_expanded), .flash_locked(flash_locked),
    .ramprot_deny(ramprot_deny), .mem_rdata(mem_rdata),
    .err_pulse(err_pulse), .err_cause(err_cause), .mem_we(mem_we),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  // expectation for the access applied in the previous cycle
  logic p_valid, p_err, p_we, p_rdv;
  logic [2:0] p_code, held_cause;
  logic [AW-1:0] p_addr;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (addr %0h)", req, act, exp, p_addr);
    end
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd1: return "R1"; 3'd2: return "R2"; 3'd3: return "R3";
      3'd4: return "R4"; 3'd5: return "R5"; 3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // reference cause code derived from the requirements
  function automatic logic [2:0] ref_code(input int a, input int k, input bit w,
      input bit wd, input bit ex, input bit lk, input bit dn);
    bit ls_w, fetch, rg, fl, im;
    fetch = (k != 0);
    ls_w  = !fetch && w;
    rg = (a >= R_LO) && (a <= R_HI);
    fl = (a >= F_LO) && (a <= F_HI);
    im = rg || fl || ((a >= M_LO) && (a <= M_HI));
    if (wd && (a % 2 == 1)) return 3'd1;   // R1
    if (fetch && rg)        return 3'd2;   // R2
    if (ls_w && fl)         return 3'd3;   // R3
    if (lk && ex && fl)     return 3'd4;   // R4
    if (!im)                return 3'd5;   // R5
    if (ls_w && dn)         return 3'd6;   // R6
    return 3'd0;
  endfunction

  task automatic step(input bit v, input int a, input int k, input bit w,
      input bit wd, input bit ex, input bit lk, input bit dn);
    logic [2:0] c;
    @(negedge clk);
    mem_rdata = DW'(~p_addr) ^ 16'h5A00;
    #1;
    if (p_valid) begin
      chk(p_err ? req_of(p_code) : "R7", int'(err_pulse), int'(p_err));
      chk("R8", int'(err_cause), int'(held_cause));
      chk("R9", int'(mem_we), int'(p_we));
      chk("R10", int'(rd_valid), int'(p_rdv));
      if (p_rdv)
        chk("R10", int'(rd_data), p_err ? 0 : int'(DW'(~p_addr) ^ 16'h5A00));
    end else begin
      chk("R7", int'(err_pulse), 0);
      chk("R8", int'(err_cause), int'(held_cause));
      chk("R9", int'(mem_we), 0);
    end
    c = ref_code(a, k, w, wd, ex, lk, dn);
    acc_valid = v; acc_addr = AW'(a); acc_kind = 2'(k); acc_write = w;
    acc_word = wd; mode_expanded = ex; flash_locked = lk; ramprot_deny = dn;
    p_valid = v; p_addr = AW'(a);
    p_err = v && (c != 0);
    p_code = c;
    p_we  = v && (k == 0) && w && (c == 0);
    p_rdv = v && !((k == 0) && w);
    if (p_err) held_cause = c;
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    p_valid = 0; p_err = 0; p_we = 0; p_rdv = 0; p_code = 0;
    held_cause = 0; p_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8", int'(err_cause), 0);
    chk("R7", int'(err_pulse), 0);
    chk("R9", int'(mem_we), 0);
    chk("R10", int'(rd_valid), 0);
    rst_n = 1'b1;
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 3; k++) begin
        for (int w = 0; w < 2; w++) begin
          for (int wd = 0; wd < 2; wd++) begin
            for (int a = 0; a < (1 << AW); a++) begin
              step(1'b1, a, k, w[0], wd[0], md[0], md[1], a[3] ^ a[5]);
            end
            step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
          end
        end
      end
    end
    // simultaneous causes: odd word fetch in register window -> R1 wins (R8)
    step(1'b1, 'h011, 1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    // locked flash write in expanded mode -> R3 outranks R4
    step(1'b1, 'h300, 0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    // deny on a RAM read has no effect (R6)
    step(1'b1, 'h120, 0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule